// File: doc/BRIEF.md
# ATA Command Fault Recovery Sequencer

This block sits in a host controller for MMC devices that carry ATA commands. It watches one ATA command in flight. A transport fault can end that command: an MMC command that gets no response, a bad CRC on a command or response, a bad data-packet CRC16, or a completion signal that does not arrive in time. When that happens, the block drives a recovery ladder through a lower-level command engine. Each rung is issued only if the rung before it succeeded. The rungs, in order, are:

1. Disable the completion signal (only when it was enabled and the block-transfer response has arrived).
2. Send a stop-transmission command.
3. Send a fast-I/O software reset.

If any rung fails, a go-idle hard reset follows, and the block reports that the device must be initialised again.

An ATA status error reported with a clean transport needs no recovery. It is reported as a plain command failure that software may retry. A host abort issued before the completion signal first disables the completion signal when one could still arrive, so that nothing collides on the command line. Every ending is reported as a one-cycle done pulse with a 2-bit outcome code.

Top module: `cmd_fault_recovery`

## Requirements
- R1: While watching a command, any of the following starts the recovery ladder, with `reqValid` high after that clock edge:
  - `dataCrcErr`;
  - `rspDone` together with `rspNoResp` or `rspCrcErr`;
  - an expired completion timer.
- R2: `ataErrSeen` while watching, with no transport fault, pulses `done` with outcome 1 and issues no request.
- R3: The first rung is completion-signal disable (`reqSpecial`=3, `reqIndex`=0). It is issued only when `irqEnabled` was high at `cmdStart` and `blockRespSeen` arrived. Otherwise the ladder starts at the stop rung.
- R4: The stop rung uses `reqIndex`=12 and `reqSpecial`=0. It succeeds only when `rspDone` comes with `rspValid` high and both error flags low.
- R5: After a successful stop, the fast-I/O rung (`reqIndex`=39, `reqSpecial`=0) is issued. Its success ends recovery with outcome 0.
- R6: When a rung fails, a hard reset (`reqIndex`=0, `reqSpecial`=0) is issued. Its `rspDone` ends recovery with outcome 2 and sets `reinitNeeded`, which stays high until the next `cmdStart`.
- R7: A request keeps `reqValid`, `reqIndex` and `reqSpecial` steady until `reqAck`. `reqValid` drops after the acknowledging edge, and no second request is raised before the pending response.
- R8: `hostAbort` while watching issues completion-signal disable when R3's condition holds, then ends with outcome 3. Without that condition it ends with outcome 3 at once, with no request.
- R9: `done` is high for exactly one cycle per recovery ending. `outcome` is valid with it: 0 recovered, 1 ATA error, 2 re-init required, 3 aborted.
- R10: The edge that samples `blockRespSeen` loads the timer with `timeoutLoad`. Without a completion pulse, the fault is taken on the (`timeoutLoad`+1)-th edge after it, so `reqValid` is still low after edge `timeoutLoad` and high after edge `timeoutLoad`+1.
- R11: `completionPulse` while watching ends the watch silently, with no `done` and no request. It wins over an expiry on the same edge. Fault inputs seen after that are ignored.
- R12: Synchronous active-high `rst` returns the block to idle, with `reqValid`, `done` and `reinitNeeded` low, even in the middle of a recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdStart | input | 1 | Pulse: an ATA command starts being watched |
| irqEnabled | input | 1 | Completion signal enabled for this command, sampled with cmdStart |
| blockRespSeen | input | 1 | Pulse: response to the multiple-block transfer command received |
| completionPulse | input | 1 | Pulse: device completion signal received |
| dataCrcErr | input | 1 | Pulse: data packet CRC16 error |
| ataErrSeen | input | 1 | Pulse: ATA status shows the error bit |
| hostAbort | input | 1 | Pulse: host abort before completion |
| timeoutLoad | input | TMR_W | Completion timeout in clock cycles |
| reqValid | output | 1 | Command request to the engine |
| reqIndex | output | 6 | Command index of the request |
| reqSpecial | output | 2 | Special-command code of the request |
| reqAck | input | 1 | Engine accepts the request |
| rspDone | input | 1 | Pulse: engine finished a response phase |
| rspValid | input | 1 | A valid response was received |
| rspNoResp | input | 1 | No response arrived |
| rspCrcErr | input | 1 | Response CRC was bad |
| done | output | 1 | One-cycle pulse at the end of recovery |
| outcome | output | 2 | Outcome code, valid with done |
| reinitNeeded | output | 1 | Device must be initialised again |

## Verification
The assertions rely on the command engine following a few rules:
- `reqAck` is raised only while `reqValid` is high.
- `rspDone` arrives on a later cycle than the acknowledge.
- Every event input is a single-cycle pulse.

The bench serves requests as an engine that respects these rules. It raises `reqAck` after a random hold of zero to three cycles and returns `rspDone` a random zero to three cycles later. It drives each event input for exactly one cycle, and only while a command is being watched. Outside those directed cases, the random scenarios draw the interrupt enable, block-response arrival, fault kind, timer value and failing rung, and compare the issued rungs and the final outcome with a ladder computed in the bench.

// File: rtl/cfr_pkg.sv
`timescale 1ns/1ps
package cfr_pkg;
  localparam int IDX_W = 6;
  localparam int SPC_W = 2;

  localparam logic [IDX_W-1:0] IDX_STOP   = 6'd12;
  localparam logic [IDX_W-1:0] IDX_FASTIO = 6'd39;
  localparam logic [IDX_W-1:0] IDX_GOIDLE = 6'd0;
  localparam logic [IDX_W-1:0] IDX_NONE   = 6'd0;
  localparam logic [SPC_W-1:0] SPC_NONE   = 2'd0;
  localparam logic [SPC_W-1:0] SPC_CSDIS  = 2'd3;

  typedef enum logic [1:0] {
    OUT_RECOVERED = 2'd0,
    OUT_ATA_ERR   = 2'd1,
    OUT_REINIT    = 2'd2,
    OUT_ABORTED   = 2'd3
  } outcome_e;

  typedef enum logic [1:0] {
    STEP_CSDIS  = 2'd0,
    STEP_STOP   = 2'd1,
    STEP_FASTIO = 2'd2,
    STEP_HARD   = 2'd3
  } step_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     arm;
    logic     clearWatch;
    logic     issue;
    step_e    step;
    logic     retire;
    logic     finish;
    outcome_e code;
  } strobe_t;

  function automatic logic [IDX_W-1:0] stepIndex(input step_e s);
    case (s)
      STEP_STOP:   return IDX_STOP;
      STEP_FASTIO: return IDX_FASTIO;
      STEP_HARD:   return IDX_GOIDLE;
      default:     return IDX_NONE;
    endcase
  endfunction

  function automatic logic [SPC_W-1:0] stepSpecial(input step_e s);
    return (s == STEP_CSDIS) ? SPC_CSDIS : SPC_NONE;
  endfunction
endpackage

// File: rtl/cfr_dp.sv
`timescale 1ns/1ps
module cfr_dp
  import cfr_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  strobe_t                stb,
  input  logic                   irqEnabled,
  input  logic                   blockRespSeen,
  input  logic [TMR_W-1:0]       timeoutLoad,
  input  logic                   reqAck,
  output logic                   expired,
  output logic                   csdNeeded,
  output logic                   reqValid,
  output logic [IDX_W-1:0]       reqIndex,
  output logic [SPC_W-1:0]       reqSpecial,
  output logic                   done,
  output outcome_e               outcome,
  output logic                   reinitNeeded
);
  logic             watchActive;
  logic             irqLatched;
  logic             blockSeen;
  logic             timing;
  logic [TMR_W-1:0] cnt;

  // watch context and completion timer
  always_ff @(posedge clk) begin
    if (rst) begin
      watchActive <= 1'b0;
      irqLatched  <= 1'b0;
      blockSeen   <= 1'b0;
      timing      <= 1'b0;
      cnt         <= '0;
    end else if (stb.arm) begin
      watchActive <= 1'b1;
      irqLatched  <= irqEnabled;
      blockSeen   <= 1'b0;
      timing      <= 1'b0;
    end else if (stb.clearWatch || stb.issue || stb.finish) begin
      watchActive <= 1'b0;
      timing      <= 1'b0;
    end else if (watchActive && blockRespSeen) begin
      blockSeen <= 1'b1;
      timing    <= 1'b1;
      cnt       <= timeoutLoad;
    end else if (timing && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired   = watchActive && timing && (cnt == '0);
  assign csdNeeded = irqLatched && blockSeen;

  // request registers towards the command engine
  always_ff @(posedge clk) begin
    if (rst) begin
      reqValid   <= 1'b0;
      reqIndex   <= IDX_NONE;
      reqSpecial <= SPC_NONE;
    end else if (stb.issue) begin
      reqValid   <= 1'b1;
      reqIndex   <= stepIndex(stb.step);
      reqSpecial <= stepSpecial(stb.step);
    end else if (stb.retire) begin
      reqValid <= 1'b0;
    end
  end

  // outcome reporting
  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      outcome      <= OUT_RECOVERED;
      reinitNeeded <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.finish) outcome <= stb.code;
      if (stb.arm) reinitNeeded <= 1'b0;
      else if (stb.finish && stb.code == OUT_REINIT) reinitNeeded <= 1'b1;
    end
  end

  // R7: a pending request is held steady until acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    reqValid && !reqAck |=> reqValid && $stable(reqIndex) && $stable(reqSpecial));

  // R9: done never lasts two cycles
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: the re-init flag only rises together with a re-init outcome
  p_reinit_flag_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(reinitNeeded) |-> done && outcome == OUT_REINIT);
endmodule

// File: rtl/cfr_ctrl.sv
`timescale 1ns/1ps
module cfr_ctrl
  import cfr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cmdStart,
  input  logic    hostAbort,
  input  logic    completionPulse,
  input  logic    dataCrcErr,
  input  logic    ataErrSeen,
  input  logic    reqAck,
  input  logic    rspDone,
  input  logic    rspValid,
  input  logic    rspNoResp,
  input  logic    rspCrcErr,
  input  logic    expired,
  input  logic    csdNeeded,
  input  logic    reqValid,
  output strobe_t stb
);
  typedef enum logic [1:0] {S_IDLE, S_WATCH, S_ISSUE, S_AWAIT} state_e;

  state_e state, stateNxt;
  step_e  curStep, stepNxt;
  logic   abortMode, abortNxt;
  logic   transportFault;
  logic   stepFailed;

  assign transportFault = dataCrcErr || (rspDone && (rspNoResp || rspCrcErr)) || expired;
  assign stepFailed = rspNoResp || rspCrcErr || (curStep == STEP_STOP && !rspValid);

  always_comb begin
    stb      = '0;
    stateNxt = state;
    stepNxt  = curStep;
    abortNxt = abortMode;
    unique case (state)
      S_IDLE: begin
        if (cmdStart) begin
          stb.arm  = 1'b1;
          stateNxt = S_WATCH;
        end
      end
      S_WATCH: begin
        if (completionPulse) begin
          stb.clearWatch = 1'b1;
          stateNxt       = S_IDLE;
        end else if (hostAbort) begin
          abortNxt = 1'b1;
          if (csdNeeded) begin
            stb.issue = 1'b1;
            stb.step  = STEP_CSDIS;
            stepNxt   = STEP_CSDIS;
            stateNxt  = S_ISSUE;
          end else begin
            stb.finish = 1'b1;
            stb.code   = OUT_ABORTED;
            stateNxt   = S_IDLE;
          end
        end else if (transportFault) begin
          abortNxt  = 1'b0;
          stb.issue = 1'b1;
          stb.step  = csdNeeded ? STEP_CSDIS : STEP_STOP;
          stepNxt   = stb.step;
          stateNxt  = S_ISSUE;
        end else if (ataErrSeen) begin
          stb.finish = 1'b1;
          stb.code   = OUT_ATA_ERR;
          stateNxt   = S_IDLE;
        end
      end
      S_ISSUE: begin
        if (reqAck) begin
          stb.retire = 1'b1;
          stateNxt   = S_AWAIT;
        end
      end
      S_AWAIT: begin
        if (rspDone) begin
          if (curStep == STEP_HARD) begin
            stb.finish = 1'b1;
            stb.code   = OUT_REINIT;
            stateNxt   = S_IDLE;
          end else if (stepFailed) begin
            stb.issue = 1'b1;
            stb.step  = STEP_HARD;
            stepNxt   = STEP_HARD;
            stateNxt  = S_ISSUE;
          end else if (curStep == STEP_CSDIS && abortMode) begin
            stb.finish = 1'b1;
            stb.code   = OUT_ABORTED;
            stateNxt   = S_IDLE;
          end else if (curStep == STEP_FASTIO) begin
            stb.finish = 1'b1;
            stb.code   = OUT_RECOVERED;
            stateNxt   = S_IDLE;
          end else begin
            stb.issue = 1'b1;
            stb.step  = (curStep == STEP_CSDIS) ? STEP_STOP : STEP_FASTIO;
            stepNxt   = stb.step;
            stateNxt  = S_ISSUE;
          end
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      curStep   <= STEP_CSDIS;
      abortMode <= 1'b0;
    end else begin
      state     <= stateNxt;
      curStep   <= stepNxt;
      abortMode <= abortNxt;
    end
  end

  // R12: nothing is requested while idle
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    state == S_IDLE |-> !reqValid);

  // R2: watching a command never drives the request line
  p_watch_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    state == S_WATCH |-> !reqValid);

  // R7: no new request while a response is pending
  p_await_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    state == S_AWAIT |-> !reqValid);
endmodule

// File: rtl/cmd_fault_recovery.sv
`timescale 1ns/1ps
module cmd_fault_recovery
  import cfr_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdStart,
  input  logic             irqEnabled,
  input  logic             blockRespSeen,
  input  logic             completionPulse,
  input  logic             dataCrcErr,
  input  logic             ataErrSeen,
  input  logic             hostAbort,
  input  logic [TMR_W-1:0] timeoutLoad,
  output logic             reqValid,
  output logic [5:0]       reqIndex,
  output logic [1:0]       reqSpecial,
  input  logic             reqAck,
  input  logic             rspDone,
  input  logic             rspValid,
  input  logic             rspNoResp,
  input  logic             rspCrcErr,
  output logic             done,
  output logic [1:0]       outcome,
  output logic             reinitNeeded
);
  strobe_t  stb;
  logic     expired;
  logic     csdNeeded;
  outcome_e outcomeInt;

  cfr_ctrl u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .cmdStart        (cmdStart),
    .hostAbort       (hostAbort),
    .completionPulse (completionPulse),
    .dataCrcErr      (dataCrcErr),
    .ataErrSeen      (ataErrSeen),
    .reqAck          (reqAck),
    .rspDone         (rspDone),
    .rspValid        (rspValid),
    .rspNoResp       (rspNoResp),
    .rspCrcErr       (rspCrcErr),
    .expired         (expired),
    .csdNeeded       (csdNeeded),
    .reqValid        (reqValid),
    .stb             (stb)
  );

  cfr_dp #(.TMR_W(TMR_W)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .stb           (stb),
    .irqEnabled    (irqEnabled),
    .blockRespSeen (blockRespSeen),
    .timeoutLoad   (timeoutLoad),
    .reqAck        (reqAck),
    .expired       (expired),
    .csdNeeded     (csdNeeded),
    .reqValid      (reqValid),
    .reqIndex      (reqIndex),
    .reqSpecial    (reqSpecial),
    .done          (done),
    .outcome       (outcomeInt),
    .reinitNeeded  (reinitNeeded)
  );

  assign outcome = outcomeInt;
endmodule

// File: tb/cmd_fault_recovery_test.sv
`timescale 1ns/1ps
module cmd_fault_recovery_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdStart = 0, irqEnabled = 0, blockRespSeen = 0, completionPulse = 0;
  logic        dataCrcErr = 0, ataErrSeen = 0, hostAbort = 0;
  logic [23:0] timeoutLoad = 24'd1000;
  logic        reqValid;
  logic [5:0]  reqIndex;
  logic [1:0]  reqSpecial;
  logic        reqAck = 0, rspDone = 0, rspValid = 0, rspNoResp = 0, rspCrcErr = 0;
  logic        done;
  logic [1:0]  outcome;
  logic        reinitNeeded;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cmd_fault_recovery uut (
    .clk(clk), .rst(rst), .cmdStart(cmdStart), .irqEnabled(irqEnabled),
    .blockRespSeen(blockRespSeen), .completionPulse(completionPulse),
    .dataCrcErr(dataCrcErr), .ataErrSeen(ataErrSeen), .hostAbort(hostAbort),
    .timeoutLoad(timeoutLoad), .reqValid(reqValid), .reqIndex(reqIndex),
    .reqSpecial(reqSpecial), .reqAck(reqAck), .rspDone(rspDone),
    .rspValid(rspValid), .rspNoResp(rspNoResp), .rspCrcErr(rspCrcErr),
    .done(done), .outcome(outcome), .reinitNeeded(reinitNeeded)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // expected ladder, computed from the requirements
  function automatic int ladderLen(input bit csd);
    return csd ? 3 : 2;
  endfunction
  function automatic int stepKind(input bit csd, input int i); // 0 disable,1 stop,2 fast-io
    return csd ? i : i + 1;
  endfunction
  function automatic logic [5:0] kindIndex(input int k);
    return (k == 1) ? 6'd12 : (k == 2) ? 6'd39 : 6'd0;
  endfunction
  function automatic logic [1:0] kindSpecial(input int k);
    return (k == 0) ? 2'd3 : 2'd0;
  endfunction
  function automatic string kindReq(input int k);
    return (k == 0) ? "R3" : (k == 1) ? "R4" : "R5";
  endfunction

  task automatic startCmd(input bit irq, input bit seen, input logic [23:0] tload);
    timeoutLoad = tload;
    irqEnabled  = irq;
    cmdStart    = 1;
    tick();
    cmdStart = 0;
    if (seen) begin
      blockRespSeen = 1;
      tick();
      blockRespSeen = 0;
    end
  endtask

  task automatic injectFault(input int kind);
    case (kind)
      0: dataCrcErr = 1;
      1: begin rspDone = 1; rspNoResp = 1; end
      default: begin rspDone = 1; rspCrcErr = 1; end
    endcase
    tick();
    dataCrcErr = 0; rspDone = 0; rspNoResp = 0; rspCrcErr = 0;
    chk("R1", "reqValid after fault", reqValid, 1);
  endtask

  task automatic serveStep(input string req, input logic [5:0] eIdx, input logic [1:0] eSpc,
                           input bit fail, input bit rv);
    chk(req, "reqValid", reqValid, 1);
    chk(req, "reqIndex", reqIndex, eIdx);
    chk(req, "reqSpecial", reqSpecial, eSpc);
    repeat ($urandom_range(0, 3)) begin
      tick();
      chk("R7", "reqValid held", reqValid, 1);
      chk("R7", "reqIndex held", reqIndex, eIdx);
    end
    reqAck = 1;
    tick();
    reqAck = 0;
    chk("R7", "reqValid after ack", reqValid, 0);
    repeat ($urandom_range(0, 3)) tick();
    rspDone  = 1;
    rspValid = rv;
    if (fail) begin
      if ($urandom_range(0, 1) == 0) rspNoResp = 1;
      else rspCrcErr = 1;
    end
    tick();
    rspDone = 0; rspValid = 0; rspNoResp = 0; rspCrcErr = 0;
  endtask

  task automatic expectDone(input string req, input logic [1:0] code);
    chk(req, "done", done, 1);
    chk(req, "outcome", outcome, code);
    tick();
    chk("R9", "done single cycle", done, 0);
  endtask

  task automatic runLadder(input bit csd, input int failAt, input bit stopNoValid);
    for (int i = 0; i < ladderLen(csd); i++) begin
      int  k = stepKind(csd, i);
      bit  noValid = (k == 1) && stopNoValid;
      bit  failEff = (i == failAt) || noValid;
      serveStep(kindReq(k), kindIndex(k), kindSpecial(k), i == failAt, !noValid);
      if (failEff) begin
        serveStep("R6", 6'd0, 2'd0, $urandom_range(0, 1) == 1, 1'b0);
        chk("R6", "reinitNeeded", reinitNeeded, 1);
        expectDone("R6", 2'd2);
        return;
      end
    end
    expectDone("R5", 2'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c1a));
    repeat (3) tick();
    chk("R12", "reqValid in reset", reqValid, 0);
    chk("R12", "done in reset", done, 0);
    chk("R12", "reinitNeeded in reset", reinitNeeded, 0);
    rst = 0;
    tick();

    // R2: ATA error, no recovery
    startCmd(1, 1, 24'd1000);
    ataErrSeen = 1;
    tick();
    ataErrSeen = 0;
    chk("R2", "no request on ATA error", reqValid, 0);
    expectDone("R2", 2'd1);
    chk("R2", "still no request", reqValid, 0);

    // R11: completion ends watch silently, later faults ignored
    startCmd(1, 1, 24'd8);
    repeat (3) tick();
    completionPulse = 1;
    tick();
    completionPulse = 0;
    chk("R11", "no done on completion", done, 0);
    repeat (15) tick();
    chk("R11", "no request after completion", reqValid, 0);
    dataCrcErr = 1;
    tick();
    dataCrcErr = 0;
    chk("R11", "fault ignored after completion", reqValid, 0);
    chk("R11", "no done after ignored fault", done, 0);

    // R10/R11 boundary: completion on the expiry edge wins
    startCmd(1, 1, 24'd6);
    repeat (6) tick();
    completionPulse = 1;
    tick();
    completionPulse = 0;
    chk("R10", "completion on expiry edge wins", reqValid, 0);
    repeat (10) tick();
    chk("R11", "quiet after late completion", reqValid, 0);

    // R10: zero timeout, interrupts off, ladder starts at stop (R3)
    startCmd(0, 1, 24'd0);
    chk("R10", "not yet expired", reqValid, 0);
    tick();
    runLadder(0, 4, 0);

    // R8: abort with completion disable
    startCmd(1, 1, 24'd1000);
    hostAbort = 1;
    tick();
    hostAbort = 0;
    serveStep("R8", 6'd0, 2'd3, 0, 1);
    expectDone("R8", 2'd3);

    // R8: abort without block response, immediate
    startCmd(1, 0, 24'd1000);
    hostAbort = 1;
    tick();
    hostAbort = 0;
    chk("R8", "no request on plain abort", reqValid, 0);
    expectDone("R8", 2'd3);

    // R8/R6: abort whose disable fails
    startCmd(1, 1, 24'd1000);
    hostAbort = 1;
    tick();
    hostAbort = 0;
    serveStep("R8", 6'd0, 2'd3, 1, 0);
    serveStep("R6", 6'd0, 2'd0, 0, 0);
    expectDone("R6", 2'd2);
    chk("R6", "reinitNeeded held", reinitNeeded, 1);

    // R6: flag cleared by next command start
    startCmd(0, 0, 24'd1000);
    chk("R6", "reinitNeeded cleared", reinitNeeded, 0);
    // R4: stop with no valid R1 response counts as failure
    injectFault(0);
    runLadder(0, 4, 1);

    // R12: reset in the middle of a recovery
    startCmd(0, 0, 24'd1000);
    injectFault(1);
    rst = 1;
    tick();
    rst = 0;
    chk("R12", "reqValid cleared by reset", reqValid, 0);
    chk("R12", "done low after reset", done, 0);
    tick();

    // random scenarios
    for (int n = 0; n < 60; n++) begin
      bit irq  = $urandom_range(0, 1) == 1;
      bit seen = $urandom_range(0, 1) == 1;
      int kind = seen ? $urandom_range(0, 3) : $urandom_range(0, 2);
      int failAt = $urandom_range(0, 4);
      bit noValid = $urandom_range(0, 7) == 0;
      if (kind == 3) begin
        int t = $urandom_range(0, 12);
        startCmd(irq, 1, 24'(t));
        repeat (t) tick();
        chk("R10", "timer not yet expired", reqValid, 0);
        tick();
        chk("R1", "timeout fault", reqValid, 1);
      end else begin
        startCmd(irq, seen, 24'd1000);
        repeat ($urandom_range(0, 5)) tick();
        injectFault(kind);
      end
      runLadder(irq && seen, failAt, noValid);
      repeat ($urandom_range(0, 2)) tick();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule